// File: doc/BRIEF.md
# Gated Bit-Slice Arithmetic Unit with Accumulator Status Flags

This block is the arithmetic core of a small accumulator-style data path. A chain of identical one-bit cells, one full adder per bit, combines an A operand and a B operand under four control lines: pass A, complement A, pass B and carry-in. The combinations of those four lines give addition, subtraction of A from B, copying A, incrementing A and the constants zero, one and minus one. The result is two's complement, 12 bits wide by default, and comes with three flags: signed overflow, non-negative and zero.

The non-negative and zero flags also feed a two-bit status register. That register samples them only on a clock edge where the accumulator is being written, so a branch unit that reads it always sees the state of the accumulator's current value, even while the arithmetic unit is busy with other work. The arithmetic path is purely combinational. The status register is the only state and has two conditions: holding, or capturing when `acc_load` is high.

Top module: `alu_status_core`

## Requirements
- R1: With `en_a`=1, `en_b`=1, `inv_a`=0, `incr`=0, `result` equals (`op_a` + `op_b`) mod 2^12.
- R2: With all four controls set to 1, `result` equals (`op_b` − `op_a`) mod 2^12, so the subtrahend is on A.
- R3: With only `en_a`=1, `result` equals `op_a`. With `en_a`=1 and `incr`=1, `result` equals (`op_a` + 1) mod 2^12.
- R4: With all controls 0, `result` is 0x000. With only `incr`=1 it is 0x001. With only `inv_a`=1 it is 0xFFF, whatever the operands are.
- R5: `ovf` is 1 exactly when the gated-A value plus the gated-B value plus carry-in, taken as signed 12-bit numbers, lies outside −2048..2047. That is the same as the carry into bit 11 differing from the carry out of bit 11.
- R6: `pos` is the inverse of `result` bit 11, so zero counts as non-negative. `zero` is 1 exactly when all 12 bits of `result` are 0.
- R7: On a rising clock edge with `acc_load`=1, `pos_q` and `zero_q` take the values of `pos` and `zero`. On an edge with `acc_load`=0 they keep their values, whatever the operands and controls are.
- R8: While `rst_n` is 0, `pos_q`=1 and `zero_q`=1, which matches a cleared accumulator.
- R9: In general, `result` = ((`op_a` AND `en_a`) XOR `inv_a`) + (`op_b` AND `en_b`) + `incr`, mod 2^12, with each control applied to every bit. The outputs follow the inputs within the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 12 | A operand, the subtrahend in subtraction |
| op_b | input | 12 | B operand (accumulator side) |
| en_a | input | 1 | Pass A into the adder |
| inv_a | input | 1 | Complement the gated A value |
| en_b | input | 1 | Pass B into the adder |
| incr | input | 1 | Carry into the lowest bit |
| acc_load | input | 1 | Accumulator is written this cycle, so the status register captures the flags |
| result | output | 12 | Adder output |
| ovf | output | 1 | Signed overflow |
| pos | output | 1 | Result is non-negative |
| zero | output | 1 | Result is zero |
| pos_q | output | 1 | Captured non-negative flag |
| zero_q | output | 1 | Captured zero flag |

## Verification
The hardest case to reach is the status register holding its value while the live flags disagree with it. The stimulus therefore loads a negative result, then drives a run of cycles with `acc_load` low whose results are zero and positive. It then checks that the captured pair has not moved before a later load. Overflow is driven from both directions: the positive limit through add and increment, and the negative limit through add and subtract. Two further cases show that the flag tracks the carries and not the operand signs alone: incrementing all ones and subtracting equal operands both produce a carry out with no overflow.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
    localparam int unsigned WORD_W = 12;

    typedef struct packed {
        logic use_a;
        logic flip_a;
        logic use_b;
        logic carry_in;
    } slice_ctl_t;
endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_slice_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  slice_ctl_t ctl,
    input  logic       cin,
    output logic       sum,
    output logic       cout
);
    logic gated_a;
    logic gated_b;

    always_comb begin
        gated_a = (a_bit & ctl.use_a) ^ ctl.flip_a;
        gated_b = b_bit & ctl.use_b;
        sum     = gated_a ^ gated_b ^ cin;
        cout    = (gated_a & gated_b) | (cin & (gated_a ^ gated_b));
    end
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
    import alu_slice_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  slice_ctl_t       ctl,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_top_in,
    output logic             carry_top_out
);
    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH:0] carry;

    assign carry[0] = ctl.carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_bit_cell u_cell (
            .a_bit (a_in[i]),
            .b_bit (b_in[i]),
            .ctl   (ctl),
            .cin   (carry[i]),
            .sum   (sum_out[i]),
            .cout  (carry[i+1])
        );
    end

    assign carry_top_in  = carry[TOP];
    assign carry_top_out = carry[WIDTH];
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
    parameter int unsigned WIDTH = 12
) (
    input  logic [WIDTH-1:0] value,
    input  logic             carry_top_in,
    input  logic             carry_top_out,
    output logic             ovf,
    output logic             pos,
    output logic             zero
);
    localparam int unsigned SIGN = WIDTH - 1;

    always_comb begin
        ovf  = carry_top_in ^ carry_top_out;
        pos  = ~value[SIGN];
        zero = ~(|value);
    end
endmodule

// File: rtl/pz_status_reg.sv
module pz_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic pos_in,
    input  logic zero_in,
    output logic pos_q,
    output logic zero_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= 1'b1;
            zero_q <= 1'b1;
        end else if (capture) begin
            pos_q  <= pos_in;
            zero_q <= zero_in;
        end
    end

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(pos_q) && $stable(zero_q)));

    // R7
    status_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (pos_q == $past(pos_in) && zero_q == $past(zero_in)));

    // R8
    status_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (pos_q && zero_q));
endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
    import alu_slice_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             en_a,
    input  logic             inv_a,
    input  logic             en_b,
    input  logic             incr,
    input  logic             acc_load,
    output logic [WIDTH-1:0] result,
    output logic             ovf,
    output logic             pos,
    output logic             zero,
    output logic             pos_q,
    output logic             zero_q
);
    localparam int unsigned SIGN = WIDTH - 1;

    slice_ctl_t ctl;
    logic       c_top_in;
    logic       c_top_out;

    assign ctl = '{use_a: en_a, flip_a: inv_a, use_b: en_b, carry_in: incr};

    alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
        .a_in          (op_a),
        .b_in          (op_b),
        .ctl           (ctl),
        .sum_out       (result),
        .carry_top_in  (c_top_in),
        .carry_top_out (c_top_out)
    );

    alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .value         (result),
        .carry_top_in  (c_top_in),
        .carry_top_out (c_top_out),
        .ovf           (ovf),
        .pos           (pos),
        .zero          (zero)
    );

    pz_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (acc_load),
        .pos_in  (pos),
        .zero_in (zero),
        .pos_q   (pos_q),
        .zero_q  (zero_q)
    );

    // R1
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a && en_b && !inv_a && !incr) |-> (result == WIDTH'(op_a + op_b)));

    // R2
    sub_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a && en_b && inv_a && incr) |-> (result == WIDTH'(op_b - op_a)));

    // R4
    const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a && !en_b && !inv_a && !incr) |-> (result == '0));

    // R5
    add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a && en_b && !inv_a && !incr) |->
        (ovf == ((op_a[SIGN] == op_b[SIGN]) && (result[SIGN] != op_a[SIGN]))));

    // R6
    zero_is_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> pos);
endmodule

// File: tb/test_alu_status_core.sv
module test_alu_status_core;
    localparam int W = 12;

    typedef struct {
        logic [W-1:0] res;
        logic         v;
        logic         p;
        logic         z;
        logic         pq;
        logic         zq;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         en_a = 1'b0, inv_a = 1'b0, en_b = 1'b0, incr = 1'b0, acc_load = 1'b0;
    logic [W-1:0] result;
    logic         ovf, pos, zero, pos_q, zero_q;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    exp_t  sbq[$];
    logic  mdl_pq = 1'b1;
    logic  mdl_zq = 1'b1;

    always #2 clk = ~clk;

    alu_status_core i_alu_status_core (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .en_a(en_a), .inv_a(inv_a), .en_b(en_b), .incr(incr),
        .acc_load(acc_load), .result(result), .ovf(ovf), .pos(pos),
        .zero(zero), .pos_q(pos_q), .zero_q(zero_q)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ea, input logic ia, input logic eb,
                         input logic ic, input logic ld, input string tag);
        exp_t e;
        int   ga, gb, sa, sb, s;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; en_a = ea; inv_a = ia; en_b = eb; incr = ic; acc_load = ld;
        ga = ea ? int'(a) : 0;
        if (ia) ga = (~ga) & 12'hFFF;
        gb = eb ? int'(b) : 0;
        s  = ga + gb + int'(ic);
        e.res = W'(s);
        sa = (ga >= 2048) ? ga - 4096 : ga;
        sb = (gb >= 2048) ? gb - 4096 : gb;
        s  = sa + sb + int'(ic);
        e.v  = (s > 2047) || (s < -2048);
        e.p  = (e.res < 12'h800);
        e.z  = (e.res == 0);
        e.pq = mdl_pq;
        e.zq = mdl_zq;
        e.tag = tag;
        sbq.push_back(e);
        if (ld) begin
            mdl_pq = e.p;
            mdl_zq = e.z;
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                cmp(e.tag, "result", int'(result), int'(e.res));
                cmp(e.tag, "ovf", int'(ovf), int'(e.v));
                cmp({e.tag, "/R6"}, "pos", int'(pos), int'(e.p));
                cmp({e.tag, "/R6"}, "zero", int'(zero), int'(e.z));
                cmp({e.tag, "/R7"}, "pos_q", int'(pos_q), int'(e.pq));
                cmp({e.tag, "/R7"}, "zero_q", int'(zero_q), int'(e.zq));
            end
        end
    end

    initial begin : watchdog
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R8", "pos_q", int'(pos_q), 1);
        cmp("R8", "zero_q", int'(zero_q), 1);
        rst_n = 1'b1;

        // add R1 / overflow R5
        drive(12'd5,   12'd7,   1, 0, 1, 0, 1, "R1");
        drive(12'h7FF, 12'h001, 1, 0, 1, 0, 0, "R1_R5");
        drive(12'h800, 12'hFFF, 1, 0, 1, 0, 0, "R1_R5");
        drive(12'hABC, 12'h544, 1, 0, 1, 0, 0, "R1");
        // subtract B-A R2
        drive(12'd3,   12'd10,  1, 1, 1, 1, 0, "R2");
        drive(12'd10,  12'd3,   1, 1, 1, 1, 1, "R2");
        drive(12'h001, 12'h800, 1, 1, 1, 1, 0, "R2_R5");
        drive(12'h555, 12'h555, 1, 1, 1, 1, 0, "R2_R5");
        // copy / increment R3
        drive(12'h123, 12'hFFF, 1, 0, 0, 0, 0, "R3");
        drive(12'h7FF, 12'h000, 1, 0, 0, 1, 0, "R3_R5");
        drive(12'hFFF, 12'h321, 1, 0, 0, 1, 0, "R3_R5");
        // constants R4
        drive(12'hFFF, 12'hFFF, 0, 0, 0, 0, 0, "R4");
        drive(12'hABC, 12'h123, 0, 0, 0, 1, 0, "R4");
        drive(12'h3C3, 12'h5A5, 0, 1, 0, 0, 0, "R4");
        // mixed combinations R9
        drive(12'h0F0, 12'h00F, 0, 1, 1, 0, 0, "R9");
        drive(12'h0F0, 12'h00F, 0, 0, 1, 1, 0, "R9");
        drive(12'h321, 12'h111, 1, 1, 0, 0, 0, "R9");
        // status register capture and hold R7
        drive(12'h000, 12'h000, 0, 0, 0, 0, 1, "R7");
        drive(12'd1,   12'd1,   1, 0, 1, 0, 0, "R7");
        drive(12'h002, 12'h001, 1, 1, 1, 1, 1, "R7");
        drive(12'h004, 12'h004, 1, 1, 1, 1, 0, "R7");
        drive(12'h010, 12'h000, 1, 0, 0, 0, 0, "R7");
        drive(12'h010, 12'h000, 1, 0, 0, 0, 1, "R7");
        drive(12'h000, 12'h000, 0, 0, 0, 0, 0, "R7");

        // reset mid-run returns status to 1/1 R8
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        cmp("R8", "pos_q", int'(pos_q), 1);
        cmp("R8", "zero_q", int'(zero_q), 1);
        mdl_pq = 1'b1;
        mdl_zq = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        drive(12'h900, 12'h000, 1, 0, 0, 0, 0, "R8");

        wait (sbq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule